// File: doc/BRIEF.md
# Programmable Decade Delay Controller

This block is the digital core of a low-power timer that can stretch its timing by a power of ten. An analog oscillator outside the block delivers a periodic tick. The block counts these ticks in a cascade of decade stages. Each stage is a divide-by-5 counter followed by a toggle, so every stage output is a square wave with a 50% duty cycle. An 8-bit configuration byte selects the division ratio. The ratio is either 1, which is bypass, or a power of ten from 10 up to 1,000,000. The same byte selects single-shot or free-running behaviour and carries two analog control bits.

In single-shot operation, a falling edge on the active-low trigger does three things: it drives the output high, enables the oscillator and starts the count. The output falls after exactly the selected number of oscillator ticks. In free-running operation, the oscillator is enabled while the trigger is held low, and the output is the tick stream divided by the ratio. With a ratio of 1, the block hands the output of an external standard-timer set/reset flag straight to the output pin and leaves the decade chain unused. Pulling the active-low reset low clears everything at once.

Top module: `dd_delay_ctrl`

## Requirements
- R1: Configuration byte fields are decoded as follows. Bits [2:0] set the ratio: code 0 and code 7 mean bypass, and code k from 1 to 6 divides by 10^k. Bit 3 set to 1 selects single-shot and 0 selects free-running. Bit 4 drives `pwr_low` and bit 5 drives `trip_low`. Bits 6 and 7 have no effect. The value held after reset equals a byte of 0x80: bypass, with both analog bits low.
- R2: In bypass, `tmr_out` follows `std_flag` combinationally and `osc_en` stays low. This holds whatever the state of bit 3 and of the trigger.
- R3: In single-shot mode, a trigger falling edge raises `tmr_out` and `osc_en` on the third rising clock edge after the edge. Two edges are spent in the synchronizer and one in the state register. `tmr_out` then stays high for exactly ratio oscillator ticks and is low right after the last of them.
- R4: A trigger falling edge that arrives during a running single-shot cycle neither restarts nor lengthens it.
- R5: When a single-shot cycle ends, `osc_en` goes low and the decade chain is back at zero, so the next cycle again lasts exactly ratio ticks.
- R6: In free-running mode, `osc_en` follows the synchronized trigger-low level. After n ticks, `tmr_out` equals floor(n / (ratio/2)) mod 2: it starts low and toggles every ratio/2 ticks.
- R7: When the trigger returns high in free-running mode, `osc_en` drops, the chain is cleared and `tmr_out` goes low.
- R8: While `rst_n` is low, `tmr_out` and `osc_en` are low with no clock edge needed. Any cycle in progress ends, and the held configuration returns to its default.
- R9: The configuration byte is sampled only while `osc_en` is low. A change made during a cycle takes effect only after that cycle ends.
- R10: Ticks that arrive while `osc_en` is low are not counted.
- R11: `pwr_low` and `trip_low` show bits 4 and 5 of the held configuration in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the timer |
| osc_tick | input | 1 | Single-cycle pulse, one per oscillator period |
| trig_n | input | 1 | Active-low trigger, asynchronous |
| cfg_byte | input | 8 | Configuration byte (ratio, mode, analog bits) |
| std_flag | input | 1 | Output of the external standard-timer set/reset flag |
| tmr_out | output | 1 | Timer output |
| osc_en | output | 1 | Enable for the external oscillator |
| pwr_low | output | 1 | Selects the low-power setting (otherwise micro) |
| trip_low | output | 1 | Selects the low-voltage trip levels (otherwise standard) |

## Verification
The clocked properties assume the following about the inputs:
- `osc_tick`, `trig_n`, `cfg_byte` and `std_flag` change only away from the rising clock edge.
- A trigger level is held long enough to pass the two-stage synchronizer.
- `cfg_byte` is re-sampled whenever the block is idle.

The stimulus meets these assumptions in three ways:
- Every input changes on the falling clock edge.
- Every trigger level is held for at least three clock cycles.
- Each configuration write is followed by two idle cycles before a trigger.

Tick spacing is drawn at random, from back-to-back ticks up to several idle cycles between them. Ticks also arrive while the oscillator is disabled, to show that they are discarded.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef struct packed {
        logic [2:0] ratio_sel;
        logic       one_shot;
        logic       pwr_low;
        logic       trip_low;
    } cfg_t;

    typedef enum logic [1:0] {
        OP_BYPASS  = 2'd0,
        OP_ONESHOT = 2'd1,
        OP_FREERUN = 2'd2
    } op_mode_e;

    localparam cfg_t CFG_DEFAULT = '{ratio_sel: 3'd0, one_shot: 1'b0,
                                     pwr_low: 1'b0, trip_low: 1'b0};

    function automatic cfg_t decode_cfg(input logic [7:0] raw);
        cfg_t c;
        c.ratio_sel = raw[2:0];
        c.one_shot  = raw[3];
        c.pwr_low   = raw[4];
        c.trip_low  = raw[5];
        return c;
    endfunction

    function automatic op_mode_e mode_of(input cfg_t c, input int unsigned stages);
        if (c.ratio_sel == 3'd0 || 32'(c.ratio_sel) > stages)
            return OP_BYPASS;
        else if (c.one_shot)
            return OP_ONESHOT;
        else
            return OP_FREERUN;
    endfunction

endpackage

// File: rtl/dd_trig_edge.sv
module dd_trig_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_n_i,
    output logic low_o,
    output logic fall_o
);
    localparam int unsigned PW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[PW-2:0], trig_n_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{pipe: '1};
        else        sync_q <= sync_d;
    end

    assign low_o  = ~sync_q.pipe[SYNC_STAGES-1];
    assign fall_o = sync_q.pipe[SYNC_STAGES] & ~sync_q.pipe[SYNC_STAGES-1];

    // One detected edge per falling transition
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dd_decade_stage.sv
module dd_decade_stage #(
    parameter int unsigned LOW_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic carry_o,
    output logic sq_o,
    output logic zero_o
);
    localparam int unsigned    CW   = (LOW_DIV > 1) ? $clog2(LOW_DIV) : 1;
    localparam logic [CW-1:0]  LAST = CW'(LOW_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          half;
    } stg_t;

    stg_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (clr_i) begin
            stg_d = '0;
        end else if (en_i) begin
            if (stg_q.cnt == LAST) begin
                stg_d.cnt  = '0;
                stg_d.half = ~stg_q.half;
            end else begin
                stg_d.cnt = stg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign carry_o = en_i && (stg_q.cnt == LAST) && stg_q.half;
    assign sq_o    = stg_q.half;
    assign zero_o  = (stg_q == '0);

    // Ticks without enable leave the stage untouched
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(stg_q));

    // A carry marks a full decade: the stage wraps to zero
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (stg_q == '0));

endmodule

// File: rtl/dd_decade_chain.sv
module dd_decade_chain #(
    parameter int unsigned STAGES  = 6,
    parameter int unsigned LOW_DIV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              tick_i,
    output logic [STAGES-1:0] carry_o,
    output logic [STAGES-1:0] sq_o,
    output logic              zero_o
);
    logic [STAGES-1:0] en_v;
    logic [STAGES-1:0] zero_v;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign en_v[g] = tick_i;
        end else begin : g_next
            assign en_v[g] = carry_o[g-1];
        end

        dd_decade_stage #(.LOW_DIV(LOW_DIV)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_i),
            .en_i    (en_v[g]),
            .carry_o (carry_o[g]),
            .sq_o    (sq_o[g]),
            .zero_o  (zero_v[g])
        );
    end

    assign zero_o = &zero_v;

endmodule

// File: rtl/dd_delay_ctrl.sv
module dd_delay_ctrl
    import dd_pkg::*;
#(
    parameter int unsigned STAGES      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       trig_n,
    input  logic [7:0] cfg_byte,
    input  logic       std_flag,
    output logic       tmr_out,
    output logic       osc_en,
    output logic       pwr_low,
    output logic       trip_low
);
    localparam int unsigned LOW_DIV = 5;

    typedef struct packed {
        cfg_t cfg;
        logic run;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              trig_low, trig_fall;
    logic [STAGES-1:0] carry_v, sq_v;
    logic              chain_zero, chain_clr, chain_tick;
    op_mode_e          mode;
    logic              osc_en_int, sel_carry, sel_sq, term_hit;

    dd_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_n_i (trig_n),
        .low_o    (trig_low),
        .fall_o   (trig_fall)
    );

    // Mode and oscillator enable come from registered state only
    always_comb begin
        mode = mode_of(ctl_q.cfg, STAGES);
        unique case (mode)
            OP_ONESHOT: osc_en_int = ctl_q.run;
            OP_FREERUN: osc_en_int = trig_low;
            default:    osc_en_int = 1'b0;
        endcase
        chain_tick = osc_tick && osc_en_int;
    end

    // Tap selection for the chosen ratio
    always_comb begin
        sel_carry = 1'b0;
        sel_sq    = 1'b0;
        for (int g = 0; g < STAGES; g++) begin
            if (ctl_q.cfg.ratio_sel == 3'(g + 1)) begin
                sel_carry = carry_v[g];
                sel_sq    = sq_v[g];
            end
        end
    end

    assign term_hit  = (mode == OP_ONESHOT) && ctl_q.run && sel_carry;
    assign chain_clr = !osc_en_int || term_hit;

    dd_decade_chain #(.STAGES(STAGES), .LOW_DIV(LOW_DIV)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (chain_clr),
        .tick_i  (chain_tick),
        .carry_o (carry_v),
        .sq_o    (sq_v),
        .zero_o  (chain_zero)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.run)
            ctl_d.run = !term_hit;
        else
            ctl_d.run = (mode == OP_ONESHOT) && trig_fall;
        if (!osc_en_int && !trig_fall)
            ctl_d.cfg = decode_cfg(cfg_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{cfg: CFG_DEFAULT, run: 1'b0};
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        unique case (mode)
            OP_ONESHOT: tmr_out = ctl_q.run;
            OP_FREERUN: tmr_out = sel_sq;
            default:    tmr_out = std_flag && rst_n;
        endcase
    end

    assign osc_en   = osc_en_int;
    assign pwr_low  = ctl_q.cfg.pwr_low;
    assign trip_low = ctl_q.cfg.trip_low;

    // Configuration frozen while the oscillator runs
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en_int |=> $stable(ctl_q.cfg));

    // A running one-shot only stops at its terminal count
    assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.run && !term_hit) |=> ctl_q.run);

    // Terminal count leaves the chain empty and the oscillator off
    assert_end_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        term_hit |=> (chain_zero && !osc_en));

    // Falling trigger in single-shot mode starts a cycle
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OP_ONESHOT && !ctl_q.run && trig_fall) |=> (tmr_out && osc_en));

    // Reset keeps both outputs quiet
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |-> (!tmr_out && !osc_en));

endmodule

// File: tb/test_dd_delay_ctrl.sv
`timescale 1ns/1ps
module test_dd_delay_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, osc_tick, trig_n, std_flag;
    logic [7:0] cfg_byte;
    logic       tmr_out, osc_en, pwr_low, trip_low;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #2.5 clk = ~clk;

    dd_delay_ctrl i_dd_delay_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .trig_n   (trig_n),
        .cfg_byte (cfg_byte),
        .std_flag (std_flag),
        .tmr_out  (tmr_out),
        .osc_en   (osc_en),
        .pwr_low  (pwr_low),
        .trip_low (trip_low)
    );

    function automatic int unsigned mult_of(input int unsigned code);
        int unsigned r = 1;
        for (int i = 0; i < int'(code); i++) r = r * 10;
        return r;
    endfunction

    // Layout: [2:0] ratio code, [3] single-shot, [4] power, [5] trip
    function automatic logic [7:0] cfg_of(input int unsigned code, input bit mono,
                                          input bit pwr, input bit trip);
        return {2'b00, trip, pwr, mono, 3'(code)};
    endfunction

    task automatic chk(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [7:0] b);
        cfg_byte = b;
        cyc(2);
    endtask

    task automatic tick_once();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Single-shot cycle: output high for exactly ratio ticks
    task automatic mono_run(input int unsigned code, input int unsigned gmax,
                            input bit retrig, input int swap_to, input string tag);
        int unsigned m   = mult_of(code);
        int unsigned bad = 0;
        trig_n = 1'b0;
        cyc(4);
        chk(tag, "start tmr_out", tmr_out, 1);
        chk(tag, "start osc_en", osc_en, 1);
        trig_n = 1'b1;
        for (int unsigned n = 1; n <= m; n++) begin
            tick_once();
            if (tmr_out !== 1'(n < m)) bad++;
            if (retrig && n == m / 2) begin
                trig_n = 1'b0;
                cyc(4);
                trig_n = 1'b1;
                cyc(3);
                if (tmr_out !== 1'b1) bad++;
            end
            if (swap_to >= 0 && n == m / 2) cfg_byte = 8'(swap_to);
            cyc($urandom_range(gmax));
        end
        chk(tag, "duration mismatches", bad, 0);
        chk("R5", "osc_en after end", osc_en, 0);
        cyc(3);
    endtask

    // Free-running: toggles every ratio/2 ticks starting low
    task automatic astable_run(input int unsigned code, input int unsigned gmax);
        int unsigned m   = mult_of(code);
        int unsigned bad = 0;
        trig_n = 1'b0;
        cyc(4);
        chk("R6", "osc_en with trigger low", osc_en, 1);
        chk("R6", "output before ticks", tmr_out, 0);
        for (int unsigned n = 1; n <= 2 * m; n++) begin
            tick_once();
            if (tmr_out !== 1'((n / (m / 2)) % 2)) bad++;
            cyc($urandom_range(gmax));
        end
        chk("R6", "R1 square wave mismatches", bad, 0);
        trig_n = 1'b1;
        cyc(4);
        chk("R7", "osc_en after release", osc_en, 0);
        chk("R7", "output after release", tmr_out, 0);
        // R10: ticks while disabled leave the chain at zero
        repeat (3) begin
            tick_once();
            cyc(1);
        end
        chk("R10", "output after idle ticks", tmr_out, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_0421));
        rst_n    = 1'b0;
        osc_tick = 1'b0;
        trig_n   = 1'b1;
        std_flag = 1'b1;
        cfg_byte = 8'h3B;
        cyc(3);
        #1;
        chk("R8", "tmr_out in reset", tmr_out, 0);
        chk("R8", "osc_en in reset", osc_en, 0);
        chk("R1", "default pwr_low", pwr_low, 0);
        chk("R1", "default trip_low", trip_low, 0);
        cfg_byte = 8'h80;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);

        // R2: bypass codes 0 and 7, mode bit either way
        for (int k = 0; k < 4; k++) begin
            set_cfg(cfg_of((k < 2) ? 0 : 7, k[0], 0, 0));
            std_flag = 1'b0;
            #1;
            chk("R2", "bypass follows flag low", tmr_out, 0);
            std_flag = 1'b1;
            #1;
            chk("R2", "bypass follows flag high", tmr_out, 1);
            trig_n = 1'b0;
            cyc(4);
            chk("R2", "bypass osc_en", osc_en, 0);
            trig_n = 1'b1;
            cyc(3);
        end

        // R11 and R1: analog bits, upper bits ignored
        set_cfg(8'h10);
        chk("R11", "pwr_low", pwr_low, 1);
        chk("R11", "trip_low", trip_low, 0);
        set_cfg(8'h20);
        chk("R11", "pwr_low", pwr_low, 0);
        chk("R11", "trip_low", trip_low, 1);
        set_cfg(8'hC0);
        std_flag = 1'b1;
        #1;
        chk("R1", "upper bits ignored, bypass", tmr_out, 1);
        chk("R1", "upper bits ignored, pwr", pwr_low, 0);

        // R10: idle ticks before a single-shot are not counted
        set_cfg(cfg_of(1, 1, 1, 1));
        chk("R11", "pwr_low single-shot", pwr_low, 1);
        for (int k = 0; k < 7; k++) begin
            tick_once();
            chk("R10", "idle output", tmr_out, 0);
        end
        mono_run(1, 2, 0, -1, "R10");

        // R3: largest tested ratio, ticks back to back
        set_cfg(cfg_of(4, 1, 0, 0));
        mono_run(4, 0, 0, -1, "R3");

        // R4: retrigger ignored
        set_cfg(cfg_of(2, 1, 0, 0));
        mono_run(2, 1, 1, -1, "R4");

        // R9: config change mid-cycle deferred
        mono_run(2, 1, 0, int'(cfg_of(1, 1, 0, 0)), "R9");
        mono_run(1, 1, 0, -1, "R9");

        // R8: reset mid-cycle
        set_cfg(cfg_of(2, 1, 1, 0));
        trig_n = 1'b0;
        cyc(4);
        trig_n = 1'b1;
        for (int k = 0; k < 30; k++) tick_once();
        chk("R8", "running before reset", tmr_out, 1);
        rst_n = 1'b0;
        #1;
        chk("R8", "tmr_out right after reset", tmr_out, 0);
        chk("R8", "osc_en right after reset", osc_en, 0);
        chk("R8", "config back to default", pwr_low, 0);
        cyc(2);
        rst_n = 1'b1;
        cyc(3);
        mono_run(2, 1, 0, -1, "R8");

        // R6/R7: directed free-running runs
        set_cfg(cfg_of(1, 0, 0, 0));
        astable_run(1, 2);
        set_cfg(cfg_of(2, 0, 0, 0));
        astable_run(2, 1);

        // Random mix
        for (int t = 0; t < 12; t++) begin
            int unsigned code = 1 + $urandom_range(2);
            bit          mono = 1'($urandom_range(1));
            set_cfg(cfg_of(code, mono, 1'($urandom_range(1)), 1'($urandom_range(1))));
            if (mono) mono_run(code, 2, 0, -1, "R3");
            else      astable_run(code, 2);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule